// File: doc/BRIEF.md
# Expansion ROM Byte Assembler

This block connects the memory-cycle side of a bus target to an external memory port that is one byte wide (ROM or EEPROM). Address decoding happens upstream, and a hit strobe reports a claimed expansion-ROM cycle. With that strobe come the command direction, the word address, the byte enables, the write data and a flag that says a burst was requested. The block then runs the external access and ends the bus data phase by raising target ready for one clock.

A read always fetches all four bytes of the addressed word, one byte at a time, whatever the byte enables say. The bytes are packed little-endian into a 32-bit word, and target ready appears only when all four bytes are in. A write programs only one byte. A write with no byte enables completes at once and leaves the external port alone. Every access first waits one turnaround clock. It then requests the external memory port from an arbiter and holds until the grant arrives. Each external byte cycle lasts a fixed access time, which is turned into a whole number of clocks. When a burst was requested, the block signals disconnect together with target ready, so only the first data phase is accepted.

Top module: `xrom_bridge`

## Requirements
- R1: A read drives the four byte addresses word*4+0, +1, +2, +3 in that order, with output enable asserted. The byte fetched at offset k appears on rdata[8k+7:8k] while trdy is high.
- R2: Each external byte cycle keeps mem_cs and exactly one of mem_oe or mem_we asserted for ACC_CYC consecutive clocks, where ACC_CYC = ceil(ACC_NS / CLK_NS). mem_addr stays constant within the cycle.
- R3: trdy stays low until the access completes and is high for exactly one clock. If the grant is sampled W clocks after arb_req first appears and the hit is sampled at edge 0, trdy becomes visible after edge 2+W+4*ACC_CYC for a read and after edge 2+W+ACC_CYC for a write.
- R4: The byte enables have no effect on a read. The bytes fetched, the data returned and the timing are the same for all 16 enable patterns.
- R5: A write with exactly one enable set drives one byte cycle with mem_we asserted. It writes byte lane L of wdata (bits 8L+7:8L, where be[L] is set) to external address word*4+L.
- R6: A write with more than one enable set writes only the lowest-numbered enabled lane. The other bytes of the word keep their values.
- R7: A write with be = 4'b0000 is a no-operation. It never raises arb_req, mem_cs or mem_we, and trdy becomes visible after edge 1.
- R8: arb_req rises after the turnaround clock and stays high until the last external byte cycle ends. No external cycle starts before arb_ack is sampled high, and the block waits as long as arb_ack stays low.
- R9: stop is high together with trdy when the burst flag was set at the hit, and stop is low otherwise.
- R10: After reset, trdy, stop, arb_req, mem_cs, mem_oe and mem_we are all low.
- R11: A hit that arrives while an access is in progress is ignored. It starts no access and changes no external byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hit | input | 1 | One-clock strobe: a decoded expansion-ROM cycle starts |
| wr | input | 1 | Command direction at the hit, 1 = write |
| burst | input | 1 | Burst requested at the hit |
| word | input | AW-2 | Word address at the hit |
| be | input | 4 | Active-high byte enables at the hit |
| wdata | input | 32 | Write data at the hit |
| trdy | output | 1 | Target ready, one-clock pulse that ends the data phase |
| stop | output | 1 | Disconnect, given together with trdy |
| rdata | output | 32 | Assembled read word, valid while trdy is high |
| arb_req | output | 1 | Request for the external memory port |
| arb_ack | input | 1 | Grant from the external memory port arbiter |
| mem_addr | output | AW | External byte address |
| mem_dout | output | 8 | External write data |
| mem_din | input | 8 | External read data |
| mem_cs | output | 1 | External chip select |
| mem_oe | output | 1 | External output enable |
| mem_we | output | 1 | External write enable |

## Verification
The bench holds the grant back for a chosen number of clocks W after arb_req appears. Counting edge 0 as the one that samples the hit, trdy is due after edge 1 for an empty write, after edge 2+W+ACC_CYC for a write and after edge 2+W+4*ACC_CYC for a read. The bench counts falling edges from the hit and records the count at which trdy is first seen. It compares that count with the figure computed from its own copy of the access time, so a clock too early or too late is reported. During the run it also checks every output-enable clock against the address it expects, word*4 plus the elapsed clocks divided by ACC_CYC. Write results are confirmed by reading each word back through the block.

// File: rtl/xrom_pkg.sv
package xrom_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_ARB,
        ST_ACC,
        ST_DONE
    } xrom_state_e;

    typedef struct packed {
        logic        wr;
        logic        burst;
        logic [3:0]  be;
        logic [31:0] wdata;
    } xrom_req_t;

    function automatic int unsigned clocks_for(input int unsigned ns, input int unsigned clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic logic [1:0] low_lane(input logic [3:0] be);
        logic [1:0] lane;
        lane = 2'd0;
        for (int i = 3; i >= 0; i--) begin
            if (be[i]) lane = 2'(i);
        end
        return lane;
    endfunction

    function automatic logic [7:0] pick_byte(input logic [31:0] w, input logic [1:0] lane);
        logic [7:0] b;
        case (lane)
            2'd0:    b = w[7:0];
            2'd1:    b = w[15:8];
            2'd2:    b = w[23:16];
            default: b = w[31:24];
        endcase
        return b;
    endfunction

endpackage

// File: rtl/xrom_timer.sv
module xrom_timer #(
    parameter int unsigned LIMIT = 19
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic last
);
    generate
        if (LIMIT <= 1) begin : g_single
            assign last = run;
        end else begin : g_count
            localparam int unsigned CW = $clog2(LIMIT);
            logic [CW-1:0] cnt;

            always_ff @(posedge clk) begin
                if (rst || !run || last) cnt <= '0;
                else                     cnt <= cnt + 1'b1;
            end

            assign last = run && (cnt == CW'(LIMIT - 1));

            p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
                cnt <= CW'(LIMIT - 1));
            p_cnt_idle_r2: assert property (@(posedge clk) disable iff (rst)
                !run |=> cnt == '0);
        end
    endgenerate
endmodule

// File: rtl/xrom_pack.sv
module xrom_pack (
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        cap,
    input  logic [1:0]  lane,
    input  logic [7:0]  din,
    output logic [31:0] word
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            word <= '0;
        end else if (cap) begin
            case (lane)
                2'd0:    word[7:0]   <= din;
                2'd1:    word[15:8]  <= din;
                2'd2:    word[23:16] <= din;
                default: word[31:24] <= din;
            endcase
        end
    end

    p_lane_written_r1: assert property (@(posedge clk) disable iff (rst)
        (cap && !clr && lane == 2'd0) |=> word[7:0] == $past(din));
    p_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (!cap && !clr) |=> $stable(word));
endmodule

// File: rtl/xrom_ctrl.sv
module xrom_ctrl
    import xrom_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        wr,
    input  logic        nop,
    input  logic        burst,
    input  logic        arb_ack,
    input  logic        beat_end,
    output xrom_state_e state,
    output logic [1:0]  beat,
    output logic        run,
    output logic        cap,
    output logic        trdy,
    output logic        stop,
    output logic        arb_req,
    output logic        mem_cs,
    output logic        mem_oe,
    output logic        mem_we
);
    xrom_state_e nxt;
    logic [1:0]  beat_nxt;

    always_comb begin
        nxt      = state;
        beat_nxt = beat;
        unique case (state)
            ST_IDLE: if (start) nxt = ST_TURN;
            ST_TURN: nxt = nop ? ST_DONE : ST_ARB;
            ST_ARB: begin
                if (arb_ack) begin
                    nxt      = ST_ACC;
                    beat_nxt = 2'd0;
                end
            end
            ST_ACC: begin
                if (beat_end) begin
                    if (wr || beat == 2'd3) nxt = ST_DONE;
                    else                    beat_nxt = beat + 2'd1;
                end
            end
            ST_DONE: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            beat  <= 2'd0;
        end else begin
            state <= nxt;
            beat  <= beat_nxt;
        end
    end

    assign run     = (state == ST_ACC);
    assign arb_req = (state == ST_ARB) || (state == ST_ACC);
    assign mem_cs  = run;
    assign mem_oe  = run && !wr;
    assign mem_we  = run && wr;
    assign cap     = mem_oe && beat_end;
    assign trdy    = (state == ST_DONE);
    assign stop    = trdy && burst;

    p_trdy_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        trdy |=> !trdy);
    p_cs_needs_req_r8: assert property (@(posedge clk) disable iff (rst)
        mem_cs |-> arb_req);
    p_wait_grant_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ARB && !arb_ack) |=> (state == ST_ARB && !mem_cs));
    p_strobe_excl_r2: assert property (@(posedge clk) disable iff (rst)
        !(mem_oe && mem_we));
    p_stop_with_trdy_r9: assert property (@(posedge clk) disable iff (rst)
        stop |-> trdy);
    p_beat_order_r1: assert property (@(posedge clk) disable iff (rst)
        (mem_oe && beat_end && beat != 2'd3) |=> (mem_oe && beat == $past(beat) + 2'd1));
endmodule

// File: rtl/xrom_bridge.sv
module xrom_bridge
    import xrom_pkg::*;
#(
    parameter int unsigned AW     = 8,
    parameter int unsigned CLK_NS = 8,
    parameter int unsigned ACC_NS = 150
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hit,
    input  logic          wr,
    input  logic          burst,
    input  logic [AW-3:0] word,
    input  logic [3:0]    be,
    input  logic [31:0]   wdata,
    output logic          trdy,
    output logic          stop,
    output logic [31:0]   rdata,
    output logic          arb_req,
    input  logic          arb_ack,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_dout,
    input  logic [7:0]    mem_din,
    output logic          mem_cs,
    output logic          mem_oe,
    output logic          mem_we
);
    localparam int unsigned ACC_CYC = clocks_for(ACC_NS, CLK_NS);
    localparam int unsigned WORD_W  = AW - 2;

    xrom_state_e      state;
    xrom_req_t        req;
    logic [WORD_W-1:0] req_word;
    logic [1:0]       beat;
    logic [1:0]       lane;
    logic             start;
    logic             nop;
    logic             run;
    logic             beat_end;
    logic             cap;

    assign start = hit && (state == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            req      <= '0;
            req_word <= '0;
        end else if (start) begin
            req.wr    <= wr;
            req.burst <= burst;
            req.be    <= be;
            req.wdata <= wdata;
            req_word  <= word;
        end
    end

    assign nop  = req.wr && (req.be == 4'b0000);
    assign lane = req.wr ? low_lane(req.be) : beat;

    xrom_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .wr       (req.wr),
        .nop      (nop),
        .burst    (req.burst),
        .arb_ack  (arb_ack),
        .beat_end (beat_end),
        .state    (state),
        .beat     (beat),
        .run      (run),
        .cap      (cap),
        .trdy     (trdy),
        .stop     (stop),
        .arb_req  (arb_req),
        .mem_cs   (mem_cs),
        .mem_oe   (mem_oe),
        .mem_we   (mem_we)
    );

    xrom_timer #(.LIMIT(ACC_CYC)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .last (beat_end)
    );

    xrom_pack u_pack (
        .clk  (clk),
        .rst  (rst),
        .clr  (start),
        .cap  (cap),
        .lane (beat),
        .din  (mem_din),
        .word (rdata)
    );

    assign mem_addr = {req_word, lane};
    assign mem_dout = pick_byte(req.wdata, lane);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> (!arb_req && !mem_cs && !trdy));
    p_nop_skip_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TURN && nop) |=> (trdy && !arb_req && !mem_cs));
    p_addr_stable_r2: assert property (@(posedge clk) disable iff (rst)
        (mem_cs && !beat_end) |=> (mem_cs && $stable(mem_addr)));
    p_cap_on_read_r4: assert property (@(posedge clk) disable iff (rst)
        cap |-> (mem_oe && !req.wr));
    p_busy_ignore_r11: assert property (@(posedge clk) disable iff (rst)
        (hit && state != ST_IDLE && state != ST_DONE) |=> $stable(req_word));
    p_rdata_hold_r1: assert property (@(posedge clk) disable iff (rst)
        trdy |=> $stable(rdata));
endmodule

// File: tb/xrom_bridge_tb.sv
module xrom_bridge_tb;
    localparam int AW     = 8;
    localparam int CLK_NS = 8;
    localparam int ACC_NS = 150;
    localparam int C      = (ACC_NS + CLK_NS - 1) / CLK_NS;
    localparam int NW     = 1 << (AW - 2);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          hit = 1'b0;
    logic          wr = 1'b0;
    logic          burst = 1'b0;
    logic [AW-3:0] word = '0;
    logic [3:0]    be = '0;
    logic [31:0]   wdata = '0;
    logic          trdy, stop, arb_req, mem_cs, mem_oe, mem_we;
    logic          arb_ack = 1'b0;
    logic [31:0]   rdata;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_dout, mem_din;

    logic [7:0] model [1 << AW];
    logic [7:0] expm  [1 << AW];

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    xrom_bridge #(.AW(AW), .CLK_NS(CLK_NS), .ACC_NS(ACC_NS)) u_dut (
        .clk(clk), .rst(rst), .hit(hit), .wr(wr), .burst(burst), .word(word),
        .be(be), .wdata(wdata), .trdy(trdy), .stop(stop), .rdata(rdata),
        .arb_req(arb_req), .arb_ack(arb_ack), .mem_addr(mem_addr),
        .mem_dout(mem_dout), .mem_din(mem_din), .mem_cs(mem_cs),
        .mem_oe(mem_oe), .mem_we(mem_we)
    );

    assign mem_din = model[mem_addr];
    always @(posedge clk) if (mem_cs && mem_we) model[mem_addr] <= mem_dout;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input int w);
        return {expm[4*w+3], expm[4*w+2], expm[4*w+1], expm[4*w]};
    endfunction

    task automatic run_acc(input logic iwr, input int iw, input logic [3:0] ibe,
                           input logic [31:0] iwd, input logic ib, input int wt,
                           input bit inject,
                           output int t_trdy, output logic s_stop, output logic [31:0] got,
                           output int n_oe, output int n_we, output int n_req,
                           output int addr_err);
        int n = -1;
        int reqcnt = 0;
        t_trdy = -1; s_stop = 1'b0; got = '0;
        n_oe = 0; n_we = 0; n_req = 0; addr_err = 0;
        @(negedge clk);
        hit = 1'b1; wr = iwr; word = (AW-2)'(iw); be = ibe; wdata = iwd; burst = ib;
        forever begin
            @(negedge clk);
            n++;
            if (n == 0) hit = 1'b0;
            if (inject && n == 3) begin
                hit = 1'b1; wr = 1'b1; word = (AW-2)'(iw ^ 1); be = 4'b0001; wdata = 32'h5A;
            end
            if (inject && n == 4) hit = 1'b0;
            if (arb_req) begin
                reqcnt++;
                n_req++;
            end
            arb_ack = arb_req && (reqcnt > wt);
            if (mem_oe) begin
                if (mem_addr != AW'(iw * 4 + n_oe / C)) addr_err++;
                n_oe++;
            end
            if (mem_we) n_we++;
            if (trdy) begin
                t_trdy = n; s_stop = stop; got = rdata;
                break;
            end
            if (n > 2000) break;
        end
        arb_ack = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int t, no, nw, nr, ae;
        logic s;
        logic [31:0] g;
        for (int i = 0; i < (1 << AW); i++) begin
            model[i] = 8'(i * 37 + 11);
            expm[i]  = 8'(i * 37 + 11);
        end
        repeat (3) @(negedge clk);
        // R10 reset state
        chk({trdy, stop, arb_req, mem_cs, mem_oe, mem_we} == 6'b0, "R10 reset outputs",
            {26'b0, trdy, stop, arb_req, mem_cs, mem_oe, mem_we}, 0);
        @(negedge clk);
        rst = 1'b0;
        chk({trdy, stop, arb_req, mem_cs} == 4'b0, "R10 after release",
            {28'b0, trdy, stop, arb_req, mem_cs}, 0);

        // R1 R3 R4 R8 R9: read every word, every enable pattern in turn
        for (int i = 0; i < NW; i++) begin
            int wt = i % 3;
            run_acc(1'b0, i, 4'(i % 16), 32'hDEAD0000 + i, 1'(i % 2), wt, 1'b0, t, s, g, no, nw, nr, ae);
            chk(g == exp_word(i), "R1 read data", g, exp_word(i));
            chk(ae == 0, "R1 byte address order", ae, 0);
            chk(t == 2 + wt + 4 * C, "R3 read trdy timing", t, 2 + wt + 4 * C);
            chk(no == 4 * C && nw == 0, "R2 R4 read strobe clocks", no, 4 * C);
            chk(nr == 1 + wt + 4 * C, "R8 request span", nr, 1 + wt + 4 * C);
            chk(s == 1'(i % 2), "R9 disconnect", s, i % 2);
        end

        // R5 R6 R7: writes with every enable pattern
        for (int b = 0; b < 16; b++) begin
            int w  = 8 + b;
            int wt = b % 2;
            logic [31:0] d = 32'hA1B2C3D4 ^ (b * 32'h01010101);
            run_acc(1'b1, w, 4'(b), d, 1'(b % 2), wt, 1'b0, t, s, g, no, nw, nr, ae);
            if (b == 0) begin
                chk(t == 1, "R7 empty write timing", t, 1);
                chk(nr == 0 && nw == 0, "R7 empty write no port", nr + nw, 0);
            end else begin
                int lane = 0;
                while (!b[lane]) lane++;
                expm[4 * w + lane] = d[8 * lane +: 8];
                chk(t == 2 + wt + C, "R3 write trdy timing", t, 2 + wt + C);
                chk(nw == C && no == 0, "R2 R5 write strobe clocks", nw, C);
            end
            chk(s == 1'(b % 2), "R9 disconnect on write", s, b % 2);
        end
        for (int b = 0; b < 16; b++) begin
            run_acc(1'b0, 8 + b, 4'hF, 0, 1'b0, 0, 1'b0, t, s, g, no, nw, nr, ae);
            chk(g == exp_word(8 + b), "R5 R6 R7 write readback", g, exp_word(8 + b));
        end

        // R11: hit during a read is dropped
        run_acc(1'b0, 40, 4'h1, 0, 1'b0, 1, 1'b1, t, s, g, no, nw, nr, ae);
        chk(g == exp_word(40) && nw == 0, "R11 busy read", g, exp_word(40));
        repeat (5) @(negedge clk);
        chk(!trdy && !arb_req, "R11 no extra access", {trdy, arb_req}, 0);
        run_acc(1'b0, 41, 4'hF, 0, 1'b0, 0, 1'b0, t, s, g, no, nw, nr, ae);
        chk(g == exp_word(41), "R11 neighbour unchanged", g, exp_word(41));

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule